// File: doc/BRIEF.md
# USB Host Endpoint List Scheduler

This block chooses, inside each USB frame, which endpoint list a host controller works on next. A frame begins with the periodic list, which carries interrupt and isochronous endpoints. After that, the remaining slots are shared between the control list and the bulk list. A programmable ratio sets how many control endpoints are served before one bulk endpoint. The block does not fetch descriptors, access memory or move packets. It only names the list that the next endpoint should come from.

Software writes a six-bit configuration word. It holds four enable bits and a two-bit ratio field that stores N-1. The host engine drives the other inputs:
- a start-of-frame pulse;
- an endpoint-done pulse each time it finishes an endpoint;
- one "nothing left" flag per list;
- an "isochronous endpoint found" flag while it walks the periodic list.

The enables are not all sampled at the same moment. The periodic enable is read at start-of-frame. The control enable is latched at start-of-frame and also re-checked at every decision. The bulk enable is read at every decision. The isochronous enable is read whenever an isochronous endpoint is met.

Top module: `usbh_list_sched`

## Requirements
- R1: After reset the configuration reads back as zero, `list_sel_o` is idle (00) and `iso_skip_o` is low. With that configuration, a start-of-frame still leaves the output idle.
- R2: The periodic list can only be entered on a start-of-frame. That happens only if the periodic enable (bit 0) is set at that edge. Setting the bit in mid-frame has no effect until the next start-of-frame.
- R3: On a start-of-frame with the periodic enable set and `per_empty_i` low, the next selection is periodic (01). The selection stays periodic at each endpoint-done until `per_empty_i` is high.
- R4: `iso_skip_o` is high while the selection is periodic, `iso_found_i` is high and the isochronous enable (bit 1) is clear. The live bit is used.
- R5: The control list (10) is selectable only if the control enable (bit 2) was set at the last start-of-frame and is still set at the decision. So setting it mid-frame waits for the next frame, and clearing it stops control selection at the next decision.
- R6: The bulk list (11) is chosen only while the bulk enable (bit 3) is set at the decision.
- R7: When both control and bulk are available, N = ratio+1 control endpoints are served, then one bulk endpoint. The ratio field is bits 5:4, so 00 means 1 and 11 means 4.
- R8: If only one of control or bulk is enabled and non-empty, that list is selected at every non-periodic decision, with no wait for the ratio count.
- R9: The count of control endpoints served returns to zero on each start-of-frame and after each bulk endpoint.
- R10: When no enabled list has work at a decision, the selection becomes idle. It stays idle, and ignores endpoint-done, until the next start-of-frame.
- R11: A configuration write stores bits 5:0 and reads back unchanged on `cfg_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Configuration word: [0] periodic, [1] isochronous, [2] control, [3] bulk, [5:4] ratio N-1 |
| cfg_rdata_o | output | 6 | Stored configuration word |
| sof_i | input | 1 | Start-of-frame pulse |
| ep_done_i | input | 1 | Current endpoint finished; take the next decision |
| per_empty_i | input | 1 | Periodic list has no endpoint left |
| ctrl_empty_i | input | 1 | Control list has no endpoint left |
| bulk_empty_i | input | 1 | Bulk list has no endpoint left |
| iso_found_i | input | 1 | Current periodic endpoint is isochronous |
| list_sel_o | output | 2 | 00 idle, 01 periodic, 10 control, 11 bulk |
| iso_skip_o | output | 1 | Skip the current isochronous endpoint |

## Verification
The assertions check several rules on every cycle:
- periodic selection starts only at a start-of-frame, and always starts there when the list is enabled and has work;
- a move into control or bulk needs the matching enable;
- idle holds between frames;
- the ratio counter stays bounded and clears after bulk.

Only the bench scenarios can show the exact interleave for each ratio value and the restart of the count at start-of-frame. They also show the frame-delayed effect of setting the control enable, compared with the immediate effect of clearing it.

// File: rtl/usbl_pkg.sv
package usbl_pkg;
  localparam int RATIO_W = 2;
  localparam int CFG_W   = RATIO_W + 4;

  typedef enum logic [1:0] {
    L_IDLE = 2'd0,
    L_PER  = 2'd1,
    L_CTRL = 2'd2,
    L_BULK = 2'd3
  } list_e;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               bulk_en;
    logic               ctrl_en;
    logic               iso_en;
    logic               per_en;
  } cfg_t;
endpackage

// File: rtl/usbl_cfg_regs.sv
module usbl_cfg_regs
  import usbl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/usbl_frame_gate.sv
module usbl_frame_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic ctrl_en_i,
  output logic ctrl_frame_en_o
);
  logic ctrl_frame_q;

  // control enable is captured per frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctrl_frame_q <= 1'b0;
    else if (sof_i) ctrl_frame_q <= ctrl_en_i;
  end

  assign ctrl_frame_en_o = ctrl_frame_q;

  p_frame_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> $stable(ctrl_frame_q));
endmodule

// File: rtl/usbl_ratio_ctr.sv
module usbl_ratio_ctr #(
  parameter int RATIO_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sof_i,
  input  logic               ctrl_done_i,
  input  logic               bulk_done_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               ctrl_turn_o
);
  localparam int CNT_W = RATIO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << RATIO_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, n_ctrl;

  assign n_ctrl = CNT_W'(ratio_i) + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (sof_i || bulk_done_i)                 cnt_d = '0;
    else if (ctrl_done_i && cnt_q < n_ctrl)   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // turn is judged on the count after this cycle's event
  assign ctrl_turn_o = (cnt_d < n_ctrl);

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  p_cnt_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i || bulk_done_i) |=> cnt_q == '0);
endmodule

// File: rtl/usbl_list_arb.sv
module usbl_list_arb
  import usbl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sof_i,
  input  logic  ep_done_i,
  input  logic  per_en_i,
  input  logic  ctrl_en_i,
  input  logic  ctrl_frame_en_i,
  input  logic  bulk_en_i,
  input  logic  per_empty_i,
  input  logic  ctrl_empty_i,
  input  logic  bulk_empty_i,
  input  logic  ctrl_turn_i,
  output list_e sel_o,
  output logic  ctrl_done_o,
  output logic  bulk_done_o
);
  list_e sel_q, sel_d;
  logic  ctrl_ok, ctrl_ok_sof, bulk_ok, step;

  function automatic list_e pick(input logic c_ok, input logic b_ok, input logic turn);
    if (c_ok && b_ok) return turn ? L_CTRL : L_BULK;
    else if (c_ok)    return L_CTRL;
    else if (b_ok)    return L_BULK;
    else              return L_IDLE;
  endfunction

  assign ctrl_ok     = ctrl_frame_en_i && ctrl_en_i && !ctrl_empty_i;
  assign ctrl_ok_sof = ctrl_en_i && !ctrl_empty_i;
  assign bulk_ok     = bulk_en_i && !bulk_empty_i;
  assign step        = ep_done_i && (sel_q != L_IDLE);

  always_comb begin
    sel_d = sel_q;
    if (sof_i) begin
      if (per_en_i && !per_empty_i) sel_d = L_PER;
      else                          sel_d = pick(ctrl_ok_sof, bulk_ok, 1'b1);
    end else if (step) begin
      if (sel_q == L_PER && !per_empty_i) sel_d = L_PER;
      else                                sel_d = pick(ctrl_ok, bulk_ok, ctrl_turn_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= L_IDLE;
    else         sel_q <= sel_d;
  end

  assign sel_o       = sel_q;
  assign ctrl_done_o = step && !sof_i && (sel_q == L_CTRL);
  assign bulk_done_o = step && !sof_i && (sel_q == L_BULK);

  p_per_only_sof_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != L_PER && !sof_i) |=> sel_q != L_PER);
  p_per_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && per_en_i && !per_empty_i) |=> sel_q == L_PER);
  p_ctrl_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != L_CTRL && (sof_i || step)) |=> (sel_q != L_CTRL || $past(ctrl_en_i)));
  p_bulk_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != L_BULK) |=> (sel_q != L_BULK || $past(bulk_en_i)));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == L_IDLE && !sof_i) |=> sel_q == L_IDLE);
endmodule

// File: rtl/usbh_list_sched.sv
module usbh_list_sched
  import usbl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  input  logic             sof_i,
  input  logic             ep_done_i,
  input  logic             per_empty_i,
  input  logic             ctrl_empty_i,
  input  logic             bulk_empty_i,
  input  logic             iso_found_i,
  output logic [1:0]       list_sel_o,
  output logic             iso_skip_o
);
  cfg_t  cfg;
  list_e sel;
  logic  ctrl_frame_en, ctrl_turn, ctrl_done, bulk_done;

  usbl_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  usbl_frame_gate u_gate (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sof_i           (sof_i),
    .ctrl_en_i       (cfg.ctrl_en),
    .ctrl_frame_en_o (ctrl_frame_en)
  );

  usbl_ratio_ctr #(.RATIO_W(RATIO_W)) u_ratio (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .ctrl_done_i (ctrl_done),
    .bulk_done_i (bulk_done),
    .ratio_i     (cfg.ratio),
    .ctrl_turn_o (ctrl_turn)
  );

  usbl_list_arb u_arb (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sof_i           (sof_i),
    .ep_done_i       (ep_done_i),
    .per_en_i        (cfg.per_en),
    .ctrl_en_i       (cfg.ctrl_en),
    .ctrl_frame_en_i (ctrl_frame_en),
    .bulk_en_i       (cfg.bulk_en),
    .per_empty_i     (per_empty_i),
    .ctrl_empty_i    (ctrl_empty_i),
    .bulk_empty_i    (bulk_empty_i),
    .ctrl_turn_i     (ctrl_turn),
    .sel_o           (sel),
    .ctrl_done_o     (ctrl_done),
    .bulk_done_o     (bulk_done)
  );

  assign cfg_rdata_o = CFG_W'(cfg);
  assign list_sel_o  = sel;
  // isochronous enable is read live at each isochronous endpoint
  assign iso_skip_o  = (sel == L_PER) && iso_found_i && !cfg.iso_en;

  p_iso_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso_skip_o |-> (list_sel_o == 2'b01 && !cfg_rdata_o[1]));
endmodule

// File: tb/usbh_list_sched_tb.sv
`timescale 1ns/1ps
module usbh_list_sched_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [5:0] cfg_wdata_i = '0;
  logic [5:0] cfg_rdata_o;
  logic       sof_i = 1'b0, ep_done_i = 1'b0;
  logic       per_empty_i = 1'b1, ctrl_empty_i = 1'b1, bulk_empty_i = 1'b1;
  logic       iso_found_i = 1'b0;
  logic [1:0] list_sel_o;
  logic       iso_skip_o;

  localparam logic [1:0] IDL = 2'd0, PER = 2'd1, CTL = 2'd2, BLK = 2'd3;

  always #2.5 clk_i = ~clk_i;

  usbh_list_sched u_dut (.*);

  typedef struct { string req; logic [1:0] exp; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare the selection one half-cycle after each decision edge
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check(it.req, {6'd0, list_sel_o}, {6'd0, it.exp});
    end
  end

  task automatic pulse(bit sof, bit done, string req, logic [1:0] exp);
    item_t it;
    @(negedge clk_i);
    sof_i = sof; ep_done_i = done;
    @(posedge clk_i); #1;
    sof_i = 0; ep_done_i = 0;
    it.req = req; it.exp = exp;
    exp_q.push_back(it);
  endtask

  task automatic wr(logic [5:0] v);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    check("R1 cfg", {2'd0, cfg_rdata_o}, 8'h00);
    check("R1 sel", {6'd0, list_sel_o}, 8'h00);
    check("R1 skip", {7'd0, iso_skip_o}, 8'h00);
    per_empty_i = 0; ctrl_empty_i = 0; bulk_empty_i = 0;
    pulse(1, 0, "R1 sof all off", IDL);
    pulse(0, 1, "R10 done in idle", IDL);

    // periodic enable mid-frame, then frame start
    wr(6'h01);
    check("R11 readback", {2'd0, cfg_rdata_o}, 8'h01);
    pulse(0, 1, "R2 per waits sof", IDL);
    pulse(1, 0, "R3 per first", PER);
    @(negedge clk_i); iso_found_i = 1; #0.5;
    check("R4 skip iso off", {7'd0, iso_skip_o}, 8'h01);
    wr(6'h03);
    check("R4 iso on", {7'd0, iso_skip_o}, 8'h00);
    check("R11 readback", {2'd0, cfg_rdata_o}, 8'h03);
    iso_found_i = 0;
    pulse(0, 1, "R3 per stays", PER);
    per_empty_i = 1;
    pulse(0, 1, "R10 nothing left", IDL);

    // bulk alone; control set mid-frame must wait
    wr(6'h0B);
    pulse(1, 0, "R8 bulk alone", BLK);
    wr(6'h0F);
    pulse(0, 1, "R5 ctrl waits frame", BLK);
    pulse(0, 1, "R5 ctrl waits frame", BLK);
    pulse(1, 0, "R5 ctrl after sof", CTL);
    pulse(0, 1, "R7 N=1 bulk", BLK);
    pulse(0, 1, "R9 ctrl after bulk", CTL);

    // ratio 3
    wr(6'h2F);
    check("R11 readback", {2'd0, cfg_rdata_o}, 8'h2F);
    pulse(0, 1, "R7 N=3", CTL);
    pulse(0, 1, "R7 N=3", CTL);
    pulse(0, 1, "R7 N=3 bulk", BLK);
    pulse(0, 1, "R9 ctrl after bulk", CTL);
    pulse(0, 1, "R7 N=3", CTL);
    pulse(1, 0, "R9 sof restarts", CTL);
    pulse(0, 1, "R9 count from 0", CTL);
    pulse(0, 1, "R9 count from 0", CTL);
    pulse(0, 1, "R9 bulk after 3", BLK);

    // ratio 4
    wr(6'h3F);
    pulse(0, 1, "R7 N=4", CTL);
    for (int i = 0; i < 3; i++) pulse(0, 1, "R7 N=4", CTL);
    pulse(0, 1, "R7 N=4 bulk", BLK);

    // bulk off: control takes every slot
    wr(6'h37);
    for (int i = 0; i < 6; i++) pulse(0, 1, "R6 R8 ctrl only", CTL);

    // control cleared mid-frame: effective at next decision
    wr(6'h0B);
    pulse(0, 1, "R5 ctrl cleared", BLK);
    pulse(0, 1, "R6 bulk on", BLK);
    bulk_empty_i = 1;
    pulse(0, 1, "R10 idle", IDL);
    bulk_empty_i = 0;
    pulse(0, 1, "R10 stays idle", IDL);
    pulse(1, 0, "R10 wake at sof", BLK);

    // periodic off at sof although list has work
    wr(6'h0A); per_empty_i = 0;
    pulse(1, 0, "R2 per off", BLK);

    // control empty with both enabled
    wr(6'h2C); ctrl_empty_i = 1;
    pulse(1, 0, "R8 ctrl empty", BLK);
    pulse(0, 1, "R8 ctrl empty", BLK);
    ctrl_empty_i = 0;
    pulse(0, 1, "R9 ctrl after bulk", CTL);

    repeat (3) @(negedge clk_i);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule